// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operands

This block is the integer execute stage of a small 32-bit RISC core. Each cycle it takes two register operands, a 16-bit immediate, a five-bit operation code and a flag that selects the immediate form. It produces a result word, an illegal-operation flag and a divide-by-zero flag. The operations are addition, subtraction, the bitwise logic family, logic against an immediate placed in the high half, compare-and-set, the three shifts, multiplication, byte and halfword sign extension, and unsigned quotient and remainder.

Optional hardware is enabled or disabled by four feature inputs: shifter, multiplier, sign extender and divider. An operation whose hardware is disabled is flagged illegal instead of executing. The immediate is sign- or zero-extended according to the operation. The surrounding core reads the flags to raise its exceptions. All three outputs are registered, so they appear one clock after the inputs.

Top module: `alu_core`

## Requirements
- R1: While `rst` is high at a rising edge, `result`, `illegal` and `div_zero` become 0. Otherwise the outputs show, one clock later, the value computed from the inputs sampled at that edge.
- R2: With `imm_form`=1, add (code 0), multiply (18), equal (9), not-equal (10), signed greater (11) and signed greater-or-equal (12) use the sign-extended `imm`. AND (2), OR (3), XOR (4), NOR (5), XNOR (6), unsigned greater (13) and unsigned greater-or-equal (14) use the zero-extended `imm`. With `imm_form`=0 these codes use `opb` instead.
- R3: High-half AND (7) and high-half OR (8) always combine `opa` with `imm` placed in bits 31:16 and zeros in bits 15:0.
- R4: The compare codes 9 to 14 produce exactly 1 when the condition on `opa` against the second operand holds, and 0 otherwise.
- R5: Shift-left (15), arithmetic shift-right (16) and logical shift-right (17) shift by `opb[4:0]` in register form and by `imm[4:0]` in immediate form. No other bits of the amount source are used.
- R6: With `has_shifter`=0, shift-left is illegal. Both right shifts are legal only when the shift amount is exactly 1.
- R7: Multiply (18, low 32 bits of the product) is illegal when `has_multiplier`=0. Byte sign extension (19) and halfword sign extension (20) of `opa` are illegal when `has_sext`=0.
- R8: Unsigned quotient (21) and remainder (22) of `opa` by `opb` are illegal when `has_divider`=0. With the divider present and `opb`=0, `div_zero` is 1, `illegal` is 0 and `result` is 0.
- R9: XNOR in immediate form gives NOT(`opa` XOR zero-extended `imm`). In register form it gives the bitwise equivalence of `opa` and `opb`.
- R10: Codes 23 to 31 are illegal. Whenever `illegal` is 1, `result` is 0.
- R11: In register form, add (0), subtract (1, `opa` minus `opb`), AND, OR, XOR and NOR give the 32-bit wrapped or bitwise result of `opa` with `opb`. Subtract ignores `imm_form`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code |
| imm_form | input | 1 | 1 selects the immediate as second operand |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| has_shifter | input | 1 | Full shifter present |
| has_multiplier | input | 1 | Multiplier present |
| has_sext | input | 1 | Sign extender present |
| has_divider | input | 1 | Divider present |
| result | output | 32 | Registered result |
| illegal | output | 1 | Registered illegal-operation flag |
| div_zero | output | 1 | Registered divide-by-zero flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit word and a 16-bit immediate. With these values the field positions in the requirements hold, and a single bench model covers the whole code space. Feature inputs are randomised per vector, so every gated operation is seen both enabled and disabled. Operand values are biased towards small numbers, so that a divisor of zero and a shift amount of exactly one occur often.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_AND  = 5'd2,  OP_OR   = 5'd3,
    OP_XOR  = 5'd4,  OP_NOR  = 5'd5,  OP_XNOR = 5'd6,  OP_ANDH = 5'd7,
    OP_ORH  = 5'd8,  OP_CEQ  = 5'd9,  OP_CNE  = 5'd10, OP_CGT  = 5'd11,
    OP_CGE  = 5'd12, OP_CGTU = 5'd13, OP_CGEU = 5'd14, OP_SHL  = 5'd15,
    OP_SHRA = 5'd16, OP_SHRL = 5'd17, OP_MUL  = 5'd18, OP_SXB  = 5'd19,
    OP_SXH  = 5'd20, OP_DIVU = 5'd21, OP_MODU = 5'd22
  } alu_op_e;

  // Immediate handling classes
  typedef enum logic [1:0] {IMM_SIGN, IMM_ZERO, IMM_HIGH, IMM_NONE} imm_kind_e;

  function automatic imm_kind_e imm_kind(input logic [4:0] op);
    case (op)
      OP_ADD, OP_MUL, OP_CEQ, OP_CNE, OP_CGT, OP_CGE,
      OP_SHL, OP_SHRA, OP_SHRL:                         imm_kind = IMM_SIGN;
      OP_AND, OP_OR, OP_XOR, OP_NOR, OP_XNOR,
      OP_CGTU, OP_CGEU:                                 imm_kind = IMM_ZERO;
      OP_ANDH, OP_ORH:                                  imm_kind = IMM_HIGH;
      default:                                          imm_kind = IMM_NONE;
    endcase
  endfunction

  function automatic logic is_compare(input logic [4:0] op);
    is_compare = (op >= OP_CEQ) && (op <= OP_CGEU);
  endfunction
endpackage

// File: rtl/alu_operand.sv
module alu_operand
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [4:0]         op_sel,
  input  logic               imm_form,
  input  logic [DATA_W-1:0]  opb,
  input  logic [IMM_W-1:0]   imm,
  output logic [DATA_W-1:0]  b_eff,
  output logic [SHAMT_W-1:0] shamt
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx, imm_zx, imm_hi;
  imm_kind_e kind;

  assign imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign imm_zx = {{PAD_W{1'b0}}, imm};
  assign imm_hi = {imm, {PAD_W{1'b0}}};
  assign kind   = imm_kind(op_sel);

  always_comb begin
    b_eff = opb;
    case (kind)
      IMM_SIGN: if (imm_form) b_eff = imm_sx;
      IMM_ZERO: if (imm_form) b_eff = imm_zx;
      IMM_HIGH: b_eff = imm_hi;
      default:  b_eff = opb;
    endcase
  end

  // shift amount: low bits of whichever operand is selected
  assign shamt = b_eff[SHAMT_W-1:0];
endmodule

// File: rtl/alu_logic_cmp.sv
module alu_logic_cmp
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] logic_res,
  output logic              cmp_bit
);
  always_comb begin
    case (op_sel)
      OP_AND, OP_ANDH: logic_res = a & b;
      OP_OR,  OP_ORH:  logic_res = a | b;
      OP_XOR:          logic_res = a ^ b;
      OP_NOR:          logic_res = ~(a | b);
      OP_XNOR:         logic_res = ~(a ^ b);
      default:         logic_res = '0;
    endcase
  end

  always_comb begin
    case (op_sel)
      OP_CEQ:  cmp_bit = (a == b);
      OP_CNE:  cmp_bit = (a != b);
      OP_CGT:  cmp_bit = ($signed(a) >  $signed(b));
      OP_CGE:  cmp_bit = ($signed(a) >= $signed(b));
      OP_CGTU: cmp_bit = (a >  b);
      OP_CGEU: cmp_bit = (a >= b);
      default: cmp_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  shl,
  output logic [DATA_W-1:0]  sra,
  output logic [DATA_W-1:0]  srl
);
  // log-depth barrel: one mux rank per amount bit
  logic [DATA_W-1:0] l_st [SHAMT_W+1];
  logic [DATA_W-1:0] a_st [SHAMT_W+1];
  logic [DATA_W-1:0] u_st [SHAMT_W+1];

  assign l_st[0] = a;
  assign a_st[0] = a;
  assign u_st[0] = a;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_rank
    localparam int D = 1 << s;
    assign l_st[s+1] = shamt[s] ? {l_st[s][DATA_W-1-D:0], {D{1'b0}}} : l_st[s];
    assign a_st[s+1] = shamt[s] ? {{D{a[DATA_W-1]}}, a_st[s][DATA_W-1:D]} : a_st[s];
    assign u_st[s+1] = shamt[s] ? {{D{1'b0}}, u_st[s][DATA_W-1:D]} : u_st[s];
  end

  assign shl = l_st[SHAMT_W];
  assign sra = a_st[SHAMT_W];
  assign srl = u_st[SHAMT_W];
endmodule

// File: rtl/alu_gate.sv
module alu_gate
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [4:0]         op_sel,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [DATA_W-1:0]  divisor,
  input  logic               has_shifter,
  input  logic               has_multiplier,
  input  logic               has_sext,
  input  logic               has_divider,
  output logic               illegal,
  output logic               div_zero
);
  localparam logic [SHAMT_W-1:0] ONE = SHAMT_W'(1);

  always_comb begin
    illegal  = 1'b0;
    div_zero = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_XNOR,
      OP_ANDH, OP_ORH, OP_CEQ, OP_CNE, OP_CGT, OP_CGE,
      OP_CGTU, OP_CGEU:  illegal = 1'b0;
      OP_SHL:            illegal = !has_shifter;
      OP_SHRA, OP_SHRL:  illegal = !has_shifter && (shamt != ONE);
      OP_MUL:            illegal = !has_multiplier;
      OP_SXB, OP_SXH:    illegal = !has_sext;
      OP_DIVU, OP_MODU: begin
        illegal  = !has_divider;
        div_zero = has_divider && (divisor == '0);
      end
      default:           illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        op_sel,
  input  logic              imm_form,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  input  logic              has_shifter,
  input  logic              has_multiplier,
  input  logic              has_sext,
  input  logic              has_divider,
  output logic [DATA_W-1:0] result,
  output logic              illegal,
  output logic              div_zero
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0]  b_eff, logic_res, shl, sra, srl;
  logic [DATA_W-1:0]  prod, quot, rem, sxb, sxh, res_c;
  logic [SHAMT_W-1:0] shamt;
  logic               cmp_bit, ill_c, dz_c;

  alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_opnd (
    .op_sel(op_sel), .imm_form(imm_form), .opb(opb), .imm(imm),
    .b_eff(b_eff), .shamt(shamt)
  );

  alu_logic_cmp #(.DATA_W(DATA_W)) u_lc (
    .op_sel(op_sel), .a(opa), .b(b_eff),
    .logic_res(logic_res), .cmp_bit(cmp_bit)
  );

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_sh (
    .a(opa), .shamt(shamt), .shl(shl), .sra(sra), .srl(srl)
  );

  alu_gate #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_gate (
    .op_sel(op_sel), .shamt(shamt), .divisor(opb),
    .has_shifter(has_shifter), .has_multiplier(has_multiplier),
    .has_sext(has_sext), .has_divider(has_divider),
    .illegal(ill_c), .div_zero(dz_c)
  );

  assign prod = opa * b_eff;
  assign quot = (opb == '0) ? '0 : opa / opb;
  assign rem  = (opb == '0) ? '0 : opa % opb;
  assign sxb  = {{(DATA_W-8){opa[7]}}, opa[7:0]};
  assign sxh  = {{(DATA_W-16){opa[15]}}, opa[15:0]};

  always_comb begin
    case (op_sel)
      OP_ADD:  res_c = opa + b_eff;
      OP_SUB:  res_c = opa - opb;
      OP_SHL:  res_c = shl;
      OP_SHRA: res_c = sra;
      OP_SHRL: res_c = srl;
      OP_MUL:  res_c = prod;
      OP_SXB:  res_c = sxb;
      OP_SXH:  res_c = sxh;
      OP_DIVU: res_c = quot;
      OP_MODU: res_c = rem;
      default: res_c = is_compare(op_sel) ? {{(DATA_W-1){1'b0}}, cmp_bit} : logic_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      illegal  <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      result   <= (ill_c || dz_c) ? '0 : res_c;
      illegal  <= ill_c;
      div_zero <= dz_c;
    end
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        op_sel,
  input logic              imm_form,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [IMM_W-1:0]  imm,
  input logic              has_shifter,
  input logic              has_multiplier,
  input logic              has_sext,
  input logic              has_divider,
  input logic [DATA_W-1:0] result,
  input logic              illegal,
  input logic              div_zero
);
  localparam int PAD_W = DATA_W - IMM_W;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !illegal && !div_zero)); // R1

  AST_HIGH_AND_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == 5'd7) |-> result[PAD_W-1:0] == '0); // R3

  AST_HIGH_OR_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == 5'd8) |-> result[PAD_W-1:0] == $past(opa[PAD_W-1:0])); // R3

  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) >= 5'd9 && $past(op_sel) <= 5'd14)
      |-> (result[DATA_W-1:1] == '0 && !illegal)); // R4

  AST_SHL_NEEDS_SHIFTER: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == 5'd15 && !$past(has_shifter)) |-> illegal); // R6

  AST_MUL_GATED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == 5'd18) |-> (illegal == !$past(has_multiplier))); // R7

  AST_DIV_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> (!illegal && result == '0 && $past(opb) == '0)); // R8

  AST_ILLEGAL_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0 && !div_zero)); // R10

  AST_UNDEF_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) >= 5'd23) |-> illegal); // R10
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .imm_form(imm_form),
  .opa(opa), .opb(opb), .imm(imm), .has_shifter(has_shifter),
  .has_multiplier(has_multiplier), .has_sext(has_sext),
  .has_divider(has_divider), .result(result), .illegal(illegal),
  .div_zero(div_zero)
);

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel = '0;
  logic        imm_form = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic        has_shifter = 1'b1, has_multiplier = 1'b1, has_sext = 1'b1, has_divider = 1'b1;
  logic [31:0] result;
  logic        illegal, div_zero;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_core u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .imm_form(imm_form),
    .opa(opa), .opb(opb), .imm(imm), .has_shifter(has_shifter),
    .has_multiplier(has_multiplier), .has_sext(has_sext),
    .has_divider(has_divider), .result(result), .illegal(illegal),
    .div_zero(div_zero)
  );

  // Expected {illegal, div_zero, result}; ft = {div, sext, mul, shifter}
  function automatic logic [33:0] model(input logic [4:0] op, input logic f,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
      input logic [3:0] ft);
    logic [31:0] bs, bz, hi, r;
    logic [4:0]  sh;
    logic        il, dz;
    bs = f ? {{16{im[15]}}, im} : b;
    bz = f ? {16'h0, im} : b;
    hi = {im, 16'h0};
    sh = f ? im[4:0] : b[4:0];
    il = 1'b0; dz = 1'b0; r = '0;
    case (op)
      5'd0:  r = a + bs;
      5'd1:  r = a - b;
      5'd2:  r = a & bz;
      5'd3:  r = a | bz;
      5'd4:  r = a ^ bz;
      5'd5:  r = ~(a | bz);
      5'd6:  r = f ? ~(a ^ {16'h0, im}) : ~(a ^ b);
      5'd7:  r = a & hi;
      5'd8:  r = a | hi;
      5'd9:  r = {31'h0, a == bs};
      5'd10: r = {31'h0, a != bs};
      5'd11: r = {31'h0, $signed(a) > $signed(bs)};
      5'd12: r = {31'h0, $signed(a) >= $signed(bs)};
      5'd13: r = {31'h0, a > bz};
      5'd14: r = {31'h0, a >= bz};
      5'd15: begin r = a << sh; il = !ft[0]; end
      5'd16: begin r = 32'($signed(a) >>> sh); il = !ft[0] && sh != 5'd1; end
      5'd17: begin r = a >> sh; il = !ft[0] && sh != 5'd1; end
      5'd18: begin r = a * bs; il = !ft[1]; end
      5'd19: begin r = {{24{a[7]}}, a[7:0]}; il = !ft[2]; end
      5'd20: begin r = {{16{a[15]}}, a[15:0]}; il = !ft[2]; end
      5'd21, 5'd22: begin
        il = !ft[3];
        dz = ft[3] && b == 0;
        if (b != 0) r = (op == 5'd21) ? a / b : a % b;
      end
      default: il = 1'b1;
    endcase
    if (il || dz) r = '0;
    model = {il, dz, r};
  endfunction

  function automatic string tag_of(input logic [4:0] op, input logic f, input logic sh_on);
    if (op <= 5'd5) return f ? "R2" : "R11";
    if (op == 5'd6) return "R9";
    if (op <= 5'd8) return "R3";
    if (op <= 5'd14) return f ? "R2" : "R4";
    if (op <= 5'd17) return sh_on ? "R5" : "R6";
    if (op <= 5'd20) return "R7";
    if (op <= 5'd22) return "R8";
    return "R10";
  endfunction

  task automatic apply(input logic [4:0] op, input logic f, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic [3:0] ft, input string tag);
    logic [33:0] exp;
    @(negedge clk);
    op_sel = op; imm_form = f; opa = a; opb = b; imm = im;
    {has_divider, has_sext, has_multiplier, has_shifter} = ft;
    exp = model(op, f, a, b, im, ft);
    @(negedge clk);
    n_vec++;
    if ({illegal, div_zero, result} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d imm_form=%0b: got ill=%0b dz=%0b res=%h, expected ill=%0b dz=%0b res=%h",
               tag, op, f, illegal, div_zero, result, exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic dir(input logic [4:0] op, input logic f, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic [3:0] ft, input string tag);
    apply(op, f, a, b, im, ft, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    // R1: reset state with busy inputs
    op_sel = 5'd0; opa = 32'h1234; opb = 32'h1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (result !== '0 || illegal !== 1'b0 || div_zero !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got res=%h ill=%0b dz=%0b, expected 0 0 0", result, illegal, div_zero);
    end
    rst = 1'b0;
    dir(5'd0, 1'b0, 32'hFFFF_FFFF, 32'h1, 16'h0, 4'hF, "R1");
    dir(5'd1, 1'b1, 32'h5, 32'h7, 16'h0003, 4'hF, "R11");           // sub ignores imm_form
    dir(5'd0, 1'b1, 32'h10, 32'h0, 16'hFFFF, 4'hF, "R2");            // add -1
    dir(5'd3, 1'b1, 32'h0, 32'h0, 16'h8001, 4'hF, "R2");             // zero-extended or
    dir(5'd11, 1'b1, 32'h0, 32'h0, 16'hFFFF, 4'hF, "R2");            // 0 > -1 signed
    dir(5'd13, 1'b1, 32'h0000_FFFE, 32'h0, 16'hFFFF, 4'hF, "R2");    // unsigned vs 0xFFFF
    dir(5'd7, 1'b0, 32'hFFFF_FFFF, 32'h0, 16'hA5A5, 4'hF, "R3");
    dir(5'd8, 1'b0, 32'h0000_1234, 32'h0, 16'h00F0, 4'hF, "R3");
    dir(5'd12, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 4'hF, "R4");
    dir(5'd14, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 4'hF, "R4");
    dir(5'd16, 1'b0, 32'h8000_0000, 32'hFFFF_FFE4, 16'h0, 4'hF, "R5"); // amount 4
    dir(5'd17, 1'b1, 32'h8000_0000, 32'h0, 16'hFFE1, 4'hF, "R5");
    dir(5'd15, 1'b0, 32'h1, 32'h1, 16'h0, 4'hE, "R6");
    dir(5'd16, 1'b0, 32'h8000_0000, 32'h1, 16'h0, 4'hE, "R6");
    dir(5'd17, 1'b0, 32'h8000_0000, 32'h2, 16'h0, 4'hE, "R6");
    dir(5'd17, 1'b1, 32'h8000_0000, 32'h0, 16'h0021, 4'hE, "R6");
    dir(5'd18, 1'b1, 32'h3, 32'h0, 16'hFFFE, 4'hF, "R7");
    dir(5'd18, 1'b0, 32'h3, 32'h3, 16'h0, 4'hD, "R7");
    dir(5'd19, 1'b0, 32'h0000_0080, 32'h0, 16'h0, 4'hF, "R7");
    dir(5'd20, 1'b0, 32'h0000_8000, 32'h0, 16'h0, 4'hB, "R7");
    dir(5'd21, 1'b0, 32'd100, 32'd7, 16'h0, 4'hF, "R8");
    dir(5'd22, 1'b0, 32'd100, 32'd7, 16'h0, 4'hF, "R8");
    dir(5'd21, 1'b0, 32'd100, 32'd0, 16'h0, 4'hF, "R8");
    dir(5'd22, 1'b0, 32'd100, 32'd0, 16'h0, 4'h7, "R8");
    dir(5'd6, 1'b1, 32'h0000_FFFF, 32'h0, 16'h00FF, 4'hF, "R9");
    dir(5'd6, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 4'hF, "R9");
    dir(5'd23, 1'b0, 32'h1, 32'h1, 16'h0, 4'hF, "R10");
    dir(5'd31, 1'b1, 32'h1, 32'h1, 16'h1, 4'hF, "R10");
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  op;
      logic [31:0] a, b;
      logic        f;
      logic [3:0]  ft;
      op = 5'($urandom_range(0, 24));
      if (op == 5'd24) op = 5'($urandom_range(23, 31));
      f  = 1'($urandom);
      a  = $urandom;
      b  = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 2)) : $urandom;
      ft = 4'($urandom);
      apply(op, f, a, b, 16'($urandom), ft, tag_of(op, f, ft[0]));
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule